// File: doc/BRIEF.md
# Clock Request Output Gating Controller

This block gates a set of differential clock output pairs. Each pair has a true side, a complement side and an output enable. Two active-low request inputs can change at any time with no relation to the reference clock. Each request input passes through a two-flop synchronizer and then a stability filter. A request level is used only after it has been seen unchanged at two rising edges in a row. A per-request ownership mask chooses which pairs that request may stop.

Each pair runs its own small state machine with three states: RUN, PARK and WAKE. In RUN the pair follows the reference clock. In PARK the pair is stopped. While the mode input is low, a parked pair drives the true side high and the complement low. While the mode input is high, a parked pair releases both sides by dropping its output enable. WAKE lasts one period. In WAKE the pair drives true high and complement low with the enable on, before it returns to RUN. This state is used only when the pair restarts from three-state parking.

The transitions are these:
- RUN→PARK (stop): the pair is owned and every owning request is withdrawn.
- PARK→RUN (release, driven parking): the stop condition clears while the mode input is low.
- PARK→WAKE (release, three-state parking): the stop condition clears while the mode input is high.
- WAKE→RUN (release held): the stop condition is still clear one period later.
- WAKE→PARK (stop again): the stop condition returns during WAKE.

All state changes happen on the rising edge of the reference clock. At that instant the true side is already high, which is the same level it holds when parked, so no output pulse is cut short.

Top module: `clkreq_gate_ctrl`

## Requirements
- R1: After reset every pair is running, meaning pad_oe=1, pad_t follows ref_clk and pad_c is its inverse. Both requests count as asserted until the filter sees otherwise.
- R2: A request level takes effect only after the synchronizer, and only once it has been captured equal at two consecutive rising edges. A level that is present at a single rising edge has no effect on any pair. A change made between edges C and C+1 reaches the pair state machines at edge C+4.
- R3: Bit req_mask[k][i]=1 gives request k control of pair i. Setting mask bits while the requests are asserted stops nothing. Clearing every owner bit of a parked pair restarts it; from three-state parking it spends one period in WAKE at the next edge and runs from the edge after.
- R4: When a request is withdrawn (req_n=1) between edges C and C+1, its owned pairs keep toggling through cycle C+3. They stop at rising edge C+4, where pad_t stays high, so the last pulse has full width.
- R5: While park_tristate=0, a parked pair drives pad_t=1, pad_c=0 and pad_oe=1.
- R6: While park_tristate=1, a parked pair has pad_oe=0, pad_t=0 and pad_c=0. A change of the mode applies at once to pairs that are already parked.
- R7: When a request is asserted again between edges C and C+1, every pair it releases restarts on the same edge. With park_tristate=0 the pairs run from edge C+4.
- R8: When a pair restarts from three-state parking, it shows pad_oe=1, pad_t=1 and pad_c=0 for the period after edge C+4. It runs from edge C+5.
- R9: A pair owned by both requests stops only while both of them are withdrawn.
- R10: A pair with no owner bit set runs at all times, whatever the request inputs and the mode input do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock; it is also the clock that drives the pairs |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | N_REQ | Asynchronous active-low clock request inputs |
| req_mask | input | N_REQ × N_PAIRS | Ownership masks; row k lists the pairs that request k may stop |
| park_tristate | input | 1 | Parking mode: 0 drives true high and complement low, 1 releases the pair |
| pad_t | output | N_PAIRS | True side of each pair |
| pad_c | output | N_PAIRS | Complement side of each pair |
| pad_oe | output | N_PAIRS | Output enable of each pair |

## Verification
The hardest case to reach is the WAKE state. A pair enters it only when all of the following hold at once:
- the pair is parked;
- the mode input is high;
- the stop condition clears, either because an owning request returns or because its last owner bit is cleared.

The stimulus reaches this case in two steps. First it parks shared and single-owner pairs under both requests in driven mode. Then it switches to three-state mode while those pairs are still parked, and reasserts one request. This produces both the immediate release of the pairs that were already parked and a synchronized WAKE period across four pairs. A one-edge pulse on a request checks that the filter rejects short levels. The bench also checks the cycle just before each expected edge, so a timing that is off by one edge shows up.

// File: rtl/clkreq_pkg.sv
package clkreq_pkg;

    // Per-pair gating states
    typedef enum logic [1:0] {
        PG_RUN  = 2'd0,
        PG_PARK = 2'd1,
        PG_WAKE = 2'd2
    } pg_state_t;

endpackage

// File: rtl/clkreq_debounce.sv
// Synchronizes one asynchronous active-low request and filters it.
// req_off is 1 when the request has been withdrawn.
module clkreq_debounce (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic req_n_async,
    output logic req_off
);

    logic meta_q;
    logic sync_q;
    logic prev_q;
    logic held_q;

    // Two-flop synchronizer, followed by a copy of the previous synced value
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= req_n_async;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Take the new level only when it matched at two consecutive edges
    assign req_off = (sync_q == prev_q) ? sync_q : held_q;

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) held_q <= 1'b0;
        else        held_q <= req_off;
    end

    AST_TWO_EDGE_STABLE: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $changed(held_q) |-> ($past(sync_q) == held_q) && ($past(sync_q, 2) == held_q)); // R2

endmodule

// File: rtl/clkreq_pair_gate.sv
// Stop/start sequencing and parking for one differential pair.
module clkreq_pair_gate
    import clkreq_pkg::*;
(
    input  logic ref_clk,
    input  logic rst_n,
    input  logic stop_req,
    input  logic park_tristate,
    output logic pad_t,
    output logic pad_c,
    output logic pad_oe
);

    pg_state_t st_q;
    pg_state_t st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PG_RUN:  if (stop_req) st_d = PG_PARK;
            PG_PARK: if (!stop_req) st_d = park_tristate ? PG_WAKE : PG_RUN;
            PG_WAKE: st_d = stop_req ? PG_PARK : PG_RUN;
            default: st_d = PG_RUN;
        endcase
    end

    // State register: updates on the rising edge, when the true side is already high
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) st_q <= PG_RUN;
        else        st_q <= st_d;
    end

    // Output drive
    always_comb begin
        pad_t  = 1'b1;
        pad_c  = 1'b0;
        pad_oe = 1'b1;
        unique case (st_q)
            PG_RUN: begin
                pad_t  = ref_clk;
                pad_c  = ~ref_clk;
                pad_oe = 1'b1;
            end
            PG_PARK: begin
                pad_t  = ~park_tristate;
                pad_c  = 1'b0;
                pad_oe = ~park_tristate;
            end
            PG_WAKE: begin
                pad_t  = 1'b1;
                pad_c  = 1'b0;
                pad_oe = 1'b1;
            end
            default: begin
                pad_t  = ref_clk;
                pad_c  = ~ref_clk;
                pad_oe = 1'b1;
            end
        endcase
    end

    AST_STOP_NEXT_EDGE: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (st_q == PG_RUN && stop_req) |=> (st_q == PG_PARK)); // R4

    AST_WAKE_FIRST: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (st_q == PG_RUN && $past(st_q) == PG_PARK) |-> !$past(park_tristate)); // R8

endmodule

// File: rtl/clkreq_gate_ctrl.sv
// Top: request filters, ownership decode, and one gate per pair.
module clkreq_gate_ctrl
    import clkreq_pkg::*;
#(
    parameter int N_PAIRS = 8,
    parameter int N_REQ   = 2
) (
    input  logic                           ref_clk,
    input  logic                           rst_n,
    input  logic [N_REQ-1:0]               req_n,
    input  logic [N_REQ-1:0][N_PAIRS-1:0]  req_mask,
    input  logic                           park_tristate,
    output logic [N_PAIRS-1:0]             pad_t,
    output logic [N_PAIRS-1:0]             pad_c,
    output logic [N_PAIRS-1:0]             pad_oe
);

    logic [N_REQ-1:0]   req_off;
    logic [N_PAIRS-1:0] owned;
    logic [N_PAIRS-1:0] keep_on;
    logic [N_PAIRS-1:0] stop_req;

    for (genvar k = 0; k < N_REQ; k++) begin : g_req
        clkreq_debounce u_deb (
            .ref_clk     (ref_clk),
            .rst_n       (rst_n),
            .req_n_async (req_n[k]),
            .req_off     (req_off[k])
        );
    end

    // A pair stops only if it has an owner and every owner has withdrawn its request
    always_comb begin
        for (int i = 0; i < N_PAIRS; i++) begin
            owned[i]   = 1'b0;
            keep_on[i] = 1'b0;
            for (int k = 0; k < N_REQ; k++) begin
                if (req_mask[k][i]) begin
                    owned[i] = 1'b1;
                    if (!req_off[k]) keep_on[i] = 1'b1;
                end
            end
        end
        stop_req = owned & ~keep_on;
    end

    for (genvar i = 0; i < N_PAIRS; i++) begin : g_pair
        clkreq_pair_gate u_gate (
            .ref_clk       (ref_clk),
            .rst_n         (rst_n),
            .stop_req      (stop_req[i]),
            .park_tristate (park_tristate),
            .pad_t         (pad_t[i]),
            .pad_c         (pad_c[i]),
            .pad_oe        (pad_oe[i])
        );

        AST_UNOWNED_LIVE: assert property (@(posedge ref_clk) disable iff (!rst_n)
            (!owned[i] && $past(!owned[i])) |-> pad_oe[i]); // R10
    end

endmodule

// File: tb/test_clkreq_gate_ctrl.sv
module test_clkreq_gate_ctrl;

    localparam int NP = 8;
    localparam int NR = 2;

    logic                   clk   = 1'b0;
    logic                   rst_n = 1'b0;
    logic [NR-1:0]          req_n = '0;
    logic [NR-1:0][NP-1:0]  mask  = '0;
    logic                   mode  = 1'b0;
    logic [NP-1:0]          pt, pc, poe;

    clkreq_gate_ctrl #(.N_PAIRS(NP), .N_REQ(NR)) i_clkreq_gate_ctrl (
        .ref_clk       (clk),
        .rst_n         (rst_n),
        .req_n         (req_n),
        .req_mask      (mask),
        .park_tristate (mode),
        .pad_t         (pt),
        .pad_c         (pc),
        .pad_oe        (poe)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int            at;
        bit            hi;
        logic [NP-1:0] t;
        logic [NP-1:0] c;
        logic [NP-1:0] oe;
        string         tag;
    } exp_t;

    exp_t sbq[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    // Driver side: run = running pairs, hz = three-state parked; others are driven-parked
    task automatic expect_pairs(int at, logic [NP-1:0] run, logic [NP-1:0] hz, string tag);
        exp_t e;
        e.at = at; e.tag = tag;
        e.hi = 1'b1; e.t = ~hz;        e.c = '0;  e.oe = ~hz;
        sbq.push_back(e);
        e.hi = 1'b0; e.t = ~run & ~hz; e.c = run; e.oe = ~hz;
        sbq.push_back(e);
    endtask

    // Monitor side
    task automatic score(bit hi);
        for (int i = sbq.size() - 1; i >= 0; i--) begin
            if (sbq[i].at < cyc || (sbq[i].at == cyc && sbq[i].hi == hi)) begin
                n_chk++;
                if (sbq[i].at < cyc) begin
                    n_fail++;
                    $display("FAIL %s: cycle %0d missed, actual none expected sample", sbq[i].tag, sbq[i].at);
                end else if (pt !== sbq[i].t || pc !== sbq[i].c || poe !== sbq[i].oe) begin
                    n_fail++;
                    $display("FAIL %s: cycle %0d phase %0d actual t=%h c=%h oe=%h expected t=%h c=%h oe=%h",
                             sbq[i].tag, cyc, hi, pt, pc, poe, sbq[i].t, sbq[i].c, sbq[i].oe);
                end
                sbq.delete(i);
            end
        end
    endtask

    initial begin
        forever begin
            @(posedge clk); #5 score(1'b1);
            @(negedge clk); #5 score(1'b0);
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        int c0;
        repeat (3) step();
        rst_n = 1'b1;
        c0 = cyc;
        expect_pairs(c0 + 1, 8'hFF, 8'h00, "R1 reset all running");
        expect_pairs(c0 + 2, 8'hFF, 8'h00, "R1 reset all running");
        repeat (3) step();

        // Ownership: req0 -> pairs 0..3, req1 -> pairs 2..5
        step();
        mask[0] = 8'h0F; mask[1] = 8'h3C;
        c0 = cyc;
        for (int k = 1; k <= 3; k++) expect_pairs(c0 + k, 8'hFF, 8'h00, "R3 masks alone stop nothing");
        repeat (4) step();

        // Withdraw req0: pairs 0,1 park driven; 2,3 shared keep running
        step();
        req_n[0] = 1'b1;
        c0 = cyc;
        expect_pairs(c0 + 3, 8'hFF, 8'h00, "R4 still toggling before stop edge");
        expect_pairs(c0 + 4, 8'hFC, 8'h00, "R4 R5 R9 req0 withdrawn");
        repeat (5) step();

        // One-edge pulse on req1 must be ignored
        step();
        req_n[1] = 1'b1;
        step();
        req_n[1] = 1'b0;
        c0 = cyc;
        for (int k = 1; k <= 5; k++) expect_pairs(c0 + k, 8'hFC, 8'h00, "R2 short pulse ignored");
        repeat (6) step();

        // Withdraw req1: shared pairs now stop too
        step();
        req_n[1] = 1'b1;
        c0 = cyc;
        expect_pairs(c0 + 3, 8'hFC, 8'h00, "R4 before stop edge");
        expect_pairs(c0 + 4, 8'hC0, 8'h00, "R9 both withdrawn");
        repeat (5) step();

        // Reassert req0: pairs 0..3 restart together
        step();
        req_n[0] = 1'b0;
        c0 = cyc;
        expect_pairs(c0 + 3, 8'hC0, 8'h00, "R7 before restart edge");
        expect_pairs(c0 + 4, 8'hCF, 8'h00, "R7 restart together");
        repeat (5) step();

        // Three-state mode applies at once to parked pairs 4,5
        step();
        mode = 1'b1;
        c0 = cyc;
        expect_pairs(c0 + 1, 8'hCF, 8'h30, "R6 parked pairs released");
        repeat (2) step();

        // Withdraw req0 in three-state mode
        step();
        req_n[0] = 1'b1;
        c0 = cyc;
        expect_pairs(c0 + 4, 8'hC0, 8'h3F, "R6 three-state parking");
        repeat (5) step();

        // Reassert req1: pairs 2..5 wake then run
        step();
        req_n[1] = 1'b0;
        c0 = cyc;
        expect_pairs(c0 + 3, 8'hC0, 8'h3F, "R8 before wake edge");
        expect_pairs(c0 + 4, 8'hC0, 8'h03, "R8 wake drives true high");
        expect_pairs(c0 + 5, 8'hFC, 8'h03, "R8 R7 running after wake");
        repeat (6) step();

        // Drop req0 ownership: pairs 0,1 become unowned and restart
        step();
        mask[0] = 8'h00;
        c0 = cyc;
        expect_pairs(c0 + 1, 8'hFC, 8'h00, "R3 unowned pair wakes");
        expect_pairs(c0 + 2, 8'hFF, 8'h00, "R3 R10 unowned pair runs");
        repeat (3) step();

        // Withdraw req1 in three-state mode; unowned pairs keep running
        step();
        req_n[1] = 1'b1;
        c0 = cyc;
        expect_pairs(c0 + 4, 8'hC3, 8'h3C, "R10 unowned pairs run");
        repeat (5) step();

        // Back to driven parking
        step();
        mode = 1'b0;
        c0 = cyc;
        expect_pairs(c0 + 1, 8'hC3, 8'h00, "R5 driven parking levels");
        repeat (3) step();

        while (sbq.size() != 0) step();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual still running expected finished");
            summary();
            $finish;
        end
    end

endmodule